// File: doc/BRIEF.md
# Bus Parity Error Reporter

This block watches a 64-bit multiplexed address/data bus together with its command/byte-enable lines and checks the even parity carried by the two parity lines. The low lane (address/data bits 31..0 with command/byte-enable bits 3..0) is always checked. The high lane (bits 63..32 with bits 7..4) is checked only while the 64-bit-transfer flag is set.

A mismatch found in a completed data phase produces a one-cycle pulse on an active-low data parity error output. A mismatch found in an address phase produces a one-cycle pulse on a pull-down enable for an open-drain system error line. Each report has its own enable input, which mirrors a command register bit.

The parity lines lag the address/data lines by one clock. The block therefore holds each phase's computed parity for one cycle and compares it when the parity lines arrive. Each report appears two clocks after the phase that carried the fault.

Top module: `pci_parity_reporter`

## Requirements
- R1: When the parity inputs make the ones count even over their lanes, no report is made: `data_err_n` stays 1 and `sys_err_pull` stays 0.
- R2: A data phase is a clock edge at which `init_rdy_n` and `tgt_rdy_n` are both 0 and `addr_phase` is 0. The parity for it is sampled at the next edge. On a low-lane mismatch, `data_err_n` is 0 for exactly the cycle that follows that second edge.
- R3: `data_err_n` goes low only if `perr_resp_en` is 1 at the edge where the parity lines are sampled.
- R4: The high lane and `par_hi` count only when `xfer64` is 1 at the phase edge. Otherwise a high-lane mismatch is ignored. When both lanes are wrong in a 64-bit phase, one single pulse results.
- R5: A mismatch in a phase with `addr_phase`=1 is reported on `sys_err_pull` with the same two-clock timing as R2, and never on `data_err_n`.
- R6: `sys_err_pull` goes high only if `serr_resp_en` is 1 at the edge where the parity lines are sampled.
- R7: `sys_err_pull`=1 means the pad pulls the system error line low, and 0 means the line is released. The block has no output that drives that line high, and it releases the line in every cycle without a report.
- R8: An edge with `init_rdy_n`=0 and `tgt_rdy_n`=1 (a wait state) or with both high is not a phase, and it produces no report even if the parity is wrong.
- R9: Faulty data phases on consecutive edges give `data_err_n` low on consecutive cycles, one cycle per phase.
- R10: While `rst_n` is 0, `data_err_n` is 1 and `sys_err_pull` is 0. A phase captured before reset produces no report after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ad | input | 64 | Address/data lines |
| cbe | input | 8 | Command/byte-enable lines |
| par_lo | input | 1 | Even parity for ad[31:0], cbe[3:0], one clock late |
| par_hi | input | 1 | Even parity for ad[63:32], cbe[7:4], one clock late |
| addr_phase | input | 1 | Current edge is an address phase |
| init_rdy_n | input | 1 | Initiator ready, active low |
| tgt_rdy_n | input | 1 | Target ready, active low |
| xfer64 | input | 1 | 64-bit transfer in progress |
| perr_resp_en | input | 1 | Command register bit 6: enables data parity reports |
| serr_resp_en | input | 1 | Command register bit 8: enables system error reports |
| data_err_n | output | 1 | Data parity error, active low |
| sys_err_pull | output | 1 | Pull-down enable for the open-drain system error line |

## Verification
The comparison for one phase and the capture of the next phase share a cycle. The hardest case is the last data phase of one transfer followed at once by the address phase of the next, with both carrying bad parity. The vector table provokes this with a faulty data phase directly followed by a faulty address phase. It judges that `data_err_n` pulses in one cycle and `sys_err_pull` in the next, with neither report bleeding into the other output.

// File: rtl/pci_parity_reporter.sv
module pci_parity_reporter #(
  parameter int LANE_W = 32,
  parameter int CBE_W  = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [2*LANE_W-1:0]   ad,
  input  logic [2*CBE_W-1:0]    cbe,
  input  logic                  par_lo,
  input  logic                  par_hi,
  input  logic                  addr_phase,
  input  logic                  init_rdy_n,
  input  logic                  tgt_rdy_n,
  input  logic                  xfer64,
  input  logic                  perr_resp_en,
  input  logic                  serr_resp_en,
  output logic                  data_err_n,
  output logic                  sys_err_pull
);
  localparam int LANES = 2;

  logic [LANES-1:0] lane_par, held_par;
  logic held_data, held_addr, held_wide;
  logic perr_q, serr_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_par[g] = ^{ad[g*LANE_W +: LANE_W], cbe[g*CBE_W +: CBE_W]};
  end

  wire data_done = !init_rdy_n && !tgt_rdy_n && !addr_phase;
  wire mismatch  = (held_par[0] ^ par_lo) | (held_wide & (held_par[1] ^ par_hi));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held_data <= 1'b0;
      held_addr <= 1'b0;
      held_wide <= 1'b0;
      held_par  <= '0;
      perr_q    <= 1'b0;
      serr_q    <= 1'b0;
    end else begin
      held_data <= data_done;
      held_addr <= addr_phase;
      held_wide <= xfer64;
      held_par  <= lane_par;
      perr_q    <= held_data & mismatch & perr_resp_en;
      serr_q    <= held_addr & mismatch & serr_resp_en;
    end
  end

  assign data_err_n   = ~perr_q;
  assign sys_err_pull = serr_q;
endmodule

module pci_parity_reporter_chk (
  input logic clk,
  input logic rst_n,
  input logic addr_phase,
  input logic init_rdy_n,
  input logic tgt_rdy_n,
  input logic perr_resp_en,
  input logic serr_resp_en,
  input logic data_err_n,
  input logic sys_err_pull
);
  a_r2_data_timing: assert property (@(posedge clk) disable iff (!rst_n)
    !data_err_n |-> $past(!init_rdy_n && !tgt_rdy_n && !addr_phase, 2));
  a_r3_perr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !data_err_n |-> $past(perr_resp_en));
  a_r5_addr_timing: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err_pull |-> $past(addr_phase, 2));
  a_r5_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(sys_err_pull && !data_err_n));
  a_r6_serr_gate: assert property (@(posedge clk) disable iff (!rst_n)
    sys_err_pull |-> $past(serr_resp_en));

  always @(negedge clk)
    if (!rst_n) a_r10_reset_idle: assert (data_err_n && !sys_err_pull);
endmodule

bind pci_parity_reporter pci_parity_reporter_chk u_chk (.*);

// File: tb/test_pci_parity_reporter.sv
module test_pci_parity_reporter;
  logic clk = 0, rst_n = 0;
  logic [63:0] ad = '0;
  logic [7:0] cbe = '0;
  logic par_lo = 0, par_hi = 0, addr_phase = 0, init_rdy_n = 1, tgt_rdy_n = 1;
  logic xfer64 = 0, perr_resp_en = 0, serr_resp_en = 0;
  logic data_err_n, sys_err_pull;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  pci_parity_reporter i_pci_parity_reporter (.*);

  typedef struct packed {
    logic [1:0] kind;  // 0 idle, 1 address, 2 data, 3 wait
    logic wide, flo, fhi, pe, se, ep, es;
    logic [63:0] ad;
    logic [7:0] cbe;
  } vec_t;

  localparam int N = 16;
  localparam vec_t VEC [N] = '{
    '{2'd2,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,64'h0123_4567_89AB_CDEF,8'h3C}, // R1
    '{2'd2,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,64'h0000_0000_0000_0001,8'h0F}, // R2
    '{2'd2,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,64'hFFFF_0000_1234_0007,8'hA5}, // R9
    '{2'd2,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,64'h5555_AAAA_5555_AAAB,8'h11}, // R9
    '{2'd2,1'b0,1'b1,1'b0,1'b0,1'b1,1'b0,1'b0,64'h1111_2222_3333_4444,8'h70}, // R3
    '{2'd2,1'b0,1'b0,1'b1,1'b1,1'b1,1'b0,1'b0,64'hDEAD_BEEF_0000_1111,8'hF0}, // R4
    '{2'd2,1'b1,1'b0,1'b1,1'b1,1'b1,1'b1,1'b0,64'hDEAD_BEEF_0000_1111,8'hF0}, // R4
    '{2'd2,1'b0,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,64'h0F0F_0F0F_F0F0_F0F1,8'h02}, // R2
    '{2'd1,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b1,64'h0000_0000_8000_0000,8'h06}, // R5
    '{2'd1,1'b0,1'b1,1'b0,1'b1,1'b0,1'b0,1'b0,64'h0000_0000_8000_0004,8'h06}, // R6
    '{2'd3,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,64'h7777_7777_7777_7777,8'h33}, // R8
    '{2'd2,1'b1,1'b1,1'b1,1'b1,1'b1,1'b1,1'b0,64'h1357_9BDF_2468_ACE0,8'h99}, // R4
    '{2'd1,1'b1,1'b0,1'b1,1'b1,1'b1,1'b0,1'b1,64'hCAFE_0000_0000_1000,8'h57}, // R5
    '{2'd0,1'b0,1'b1,1'b0,1'b1,1'b1,1'b0,1'b0,64'h8888_8888_8888_8888,8'h00}, // R8
    '{2'd2,1'b1,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,64'hFEDC_BA98_7654_3210,8'hE1}, // R1
    '{2'd1,1'b0,1'b0,1'b0,1'b1,1'b1,1'b0,1'b0,64'h0000_0000_0000_0040,8'h07}  // R7
  };

  task automatic check(input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b", what, act, exp);
    end
  endtask

  task automatic drive_phase(input vec_t v);
    ad = v.ad; cbe = v.cbe; xfer64 = v.wide;
    addr_phase = (v.kind == 2'd1);
    init_rdy_n = !(v.kind == 2'd2 || v.kind == 2'd3);
    tgt_rdy_n  = !(v.kind == 2'd2);
  endtask

  task automatic drive_par(input vec_t v);
    par_lo = ^{v.ad[31:0], v.cbe[3:0]} ^ v.flo;
    par_hi = ^{v.ad[63:32], v.cbe[7:4]} ^ v.fhi;
    perr_resp_en = v.pe; serr_resp_en = v.se;
  endtask

  initial begin
    #1000000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    vec_t idle_v;
    idle_v = '0;
    repeat (2) @(negedge clk);
    check(data_err_n, 1'b1, "R10 reset data_err_n");
    check(sys_err_pull, 1'b0, "R10 reset sys_err_pull");
    rst_n = 1;
    for (int i = 0; i <= N + 1; i++) begin
      @(negedge clk);
      if (i >= 2) begin
        check(data_err_n, !VEC[i-2].ep, $sformatf("R2/R3/R4/R9 vec %0d data_err_n", i-2));
        check(sys_err_pull, VEC[i-2].es, $sformatf("R5/R6/R7 vec %0d sys_err_pull", i-2));
      end
      drive_phase(i < N ? VEC[i] : idle_v);
      if (i >= 1 && i <= N) drive_par(VEC[i-1]); else drive_par(idle_v);
    end
    // R10: phase captured before reset must not report after it
    @(negedge clk);
    drive_phase(VEC[1]);
    @(negedge clk);
    drive_phase(idle_v);
    drive_par(VEC[1]);
    rst_n = 0;
    #1;
    check(data_err_n, 1'b1, "R10 mid-pipeline reset data_err_n");
    check(sys_err_pull, 1'b0, "R10 mid-pipeline reset sys_err_pull");
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(data_err_n, 1'b1, "R10 pipeline cleared");
    @(negedge clk);
    check(data_err_n, 1'b1, "R7 idle after reset");
    check(sys_err_pull, 1'b0, "R7 line released");
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule